// File: doc/BRIEF.md
# Center-Aligned Up/Down PWM Timer

This block is a timer that generates a symmetric, center-aligned pulse-width modulated waveform. Its counter climbs from zero to the top of its range and then descends back to zero, one step per enabled tick, and repeats. Because the slope is triangular, one compare threshold produces two output edges per period. These two edges sit at equal distances from the turning points of the ramp, so the pulse centre does not move when the duty cycle changes. This suits loads such as motor bridges.

A host writes a new threshold into a shadow register at any time. The threshold becomes active only when the counter turns at the top, so a period never mixes two duty values. A two-bit mode input selects one of four pin behaviours: disconnected (pin held low), toggle on every match, non-inverting PWM, or inverting PWM. Single-cycle flags report the bottom turnaround and every compare match. Tick generation and any bus access sit outside the block.

Top module: `pcpwm_timer`

## Requirements
- R1: On every enabled tick the counter moves one step. It rises from 0 to MAX (2**CNT_W-1, 255 by default) and then falls back to 0. Each turning value is shown for exactly one tick, so one period is 2*MAX ticks.
- R2: When `tick` is low, the counter, the direction and the pin keep their values, and both flags stay low.
- R3: `ovf_pulse` is high for one clock cycle: the cycle in which `count` first shows 0 after a falling step. It is never high at any other time.
- R4: `match_pulse` is high for one clock cycle after a clock edge at which `tick` was high and `count` equalled the active threshold.
- R5: With mode 2'b10 (non-inverting), a match clears the pin while the ramp is rising and sets it while the ramp is falling. The value 0 counts as rising and MAX counts as falling.
- R6: With mode 2'b11 (inverting), a match sets the pin while rising and clears it while falling.
- R7: With mode 2'b01, every match inverts the pin.
- R8: With mode 2'b00, the pin reads low, and matches do not change the internal pin state.
- R9: A write (`cmp_wr` high) stores `cmp_wdata` only in the shadow register. The shadow value moves into the active threshold at the clock edge where a rising tick brings the counter to MAX. Writes at other times do not change the waveform until that edge.
- R10: In non-inverting mode, an active threshold of 0 keeps the pin low for the whole period. An active threshold of MAX keeps it high for the whole period once it has been set.
- R11: After reset, the counter is 0, the ramp is rising, the shadow and active thresholds are 0, the pin is low and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable for this cycle |
| cmp_wr | input | 1 | Write strobe for the shadow threshold |
| cmp_wdata | input | CNT_W | New threshold value |
| out_mode | input | 2 | Pin mode: 0 off, 1 toggle, 2 non-inverting, 3 inverting |
| pwm_out | output | 1 | Waveform pin |
| count | output | CNT_W | Current counter value |
| ovf_pulse | output | 1 | Bottom-reached flag |
| match_pulse | output | 1 | Compare-match flag |

## Verification
The properties assume that `out_mode` is one of the four defined codes and that `tick` is a plain level sampled at each clock edge. No other assumption about the input pattern is made. The stimulus changes every input only on the falling clock edge, holds `out_mode` fixed through each phase, and drives `cmp_wr` only as a one-cycle strobe. Thresholds are written at arbitrary points on both slopes. This places writes both close to and far from the top-turn transfer, while each phase still runs with the tick either continuous or sparse.

// File: rtl/pcpwm_pkg.sv
`timescale 1ns/1ps
package pcpwm_pkg;

   typedef enum logic [1:0] {
      PM_OFF    = 2'b00,
      PM_TOGGLE = 2'b01,
      PM_NONINV = 2'b10,
      PM_INV    = 2'b11
   } pin_mode_e;

   function automatic logic next_pin
     (input pin_mode_e mode, input logic rising, input logic cur);
      logic r;
      case (mode)
         PM_TOGGLE: r = ~cur;
         PM_NONINV: r = ~rising;
         PM_INV:    r = rising;
         default:   r = cur;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pcpwm_updown_cnt.sv
`timescale 1ns/1ps
module pcpwm_updown_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             rising,
   output logic             top_load,
   output logic             bottom_pulse
);
   localparam logic [CNT_W-1:0] TOP     = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] TOP_M1  = TOP - 1'b1;
   localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

   logic at_pre_top;
   logic at_pre_bot;

   assign at_pre_top = (cnt == TOP_M1);
   assign at_pre_bot = (cnt == ONE);
   assign top_load   = tick & rising & at_pre_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt          <= '0;
         rising       <= 1'b1;
         bottom_pulse <= 1'b0;
      end else begin
         bottom_pulse <= 1'b0;
         if (tick) begin
            if (rising) begin
               cnt <= cnt + ONE;
               if (at_pre_top) rising <= 1'b0;
            end else begin
               cnt <= cnt - ONE;
               if (at_pre_bot) begin
                  rising       <= 1'b1;
                  bottom_pulse <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/pcpwm_cmp_dbuf.sv
`timescale 1ns/1ps
module pcpwm_cmp_dbuf #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             load,
   output logic [CNT_W-1:0] active
);
   logic [CNT_W-1:0] shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (wr) begin
         shadow <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= '0;
      end else if (load) begin
         active <= shadow;
      end
   end
endmodule

// File: rtl/pcpwm_wavegen.sv
`timescale 1ns/1ps
module pcpwm_wavegen
   import pcpwm_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic             rising,
   input  logic [CNT_W-1:0] thresh,
   input  pin_mode_e        mode,
   output logic             pin,
   output logic             match_q
);
   logic hit;
   logic oc_q;
   logic pin_raw;

   assign hit = tick & (cnt == thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc_q    <= 1'b0;
         match_q <= 1'b0;
      end else begin
         match_q <= hit;
         if (hit) oc_q <= next_pin(mode, rising, oc_q);
      end
   end

   assign pin_raw = (mode == PM_OFF) ? 1'b0 : oc_q;

   generate
      if (OUT_REG) begin : g_pin_reg
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= pin_raw;
         end
         assign pin = pin_q;
      end else begin : g_pin_comb
         assign pin = pin_raw;
      end
   endgenerate
endmodule

// File: rtl/pcpwm_timer.sv
`timescale 1ns/1ps
module pcpwm_timer
   import pcpwm_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic [1:0]       out_mode,
   output logic             pwm_out,
   output logic [CNT_W-1:0] count,
   output logic             ovf_pulse,
   output logic             match_pulse
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("pcpwm_timer: CNT_W must lie in 2..16");
      end
   endgenerate

   logic             dir_up;
   logic             load;
   logic [CNT_W-1:0] cmp_act;
   pin_mode_e        mode;

   assign mode = pin_mode_e'(out_mode);

   pcpwm_updown_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .cnt          (count),
      .rising       (dir_up),
      .top_load     (load),
      .bottom_pulse (ovf_pulse)
   );

   pcpwm_cmp_dbuf #(.CNT_W(CNT_W)) u_dbuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (cmp_wr),
      .wdata  (cmp_wdata),
      .load   (load),
      .active (cmp_act)
   );

   pcpwm_wavegen #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cnt     (count),
      .rising  (dir_up),
      .thresh  (cmp_act),
      .mode    (mode),
      .pin     (pwm_out),
      .match_q (match_pulse)
   );
endmodule

// File: rtl/pcpwm_timer_chk.sv
`timescale 1ns/1ps
module pcpwm_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [1:0]       out_mode,
   input logic             pwm_out,
   input logic [CNT_W-1:0] count,
   input logic             ovf_pulse,
   input logic             match_pulse,
   input logic             dir_up,
   input logic             load,
   input logic [CNT_W-1:0] cmp_act
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (count != $past(count)));

   assert_top_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (count == TOP) |-> !dir_up);

   assert_bottom_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> dir_up);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(count) && !ovf_pulse && !match_pulse));

   assert_ovf_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (count == '0));

   assert_ovf_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> !ovf_pulse);

   assert_match_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> $past(tick));

   assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mode == 2'b00) |-> !pwm_out);

   assert_act_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cmp_act));
endmodule

bind pcpwm_timer pcpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .out_mode    (out_mode),
   .pwm_out     (pwm_out),
   .count       (count),
   .ovf_pulse   (ovf_pulse),
   .match_pulse (match_pulse),
   .dir_up      (dir_up),
   .load        (load),
   .cmp_act     (cmp_act)
);

// File: tb/sim_pcpwm_timer.sv
`timescale 1ns/1ps
module sim_pcpwm_timer;
   localparam int W = 8;
   localparam logic [W-1:0] TOP = 8'hFF;

   typedef struct {
      logic [W-1:0] cnt;
      logic         pin;
      logic         ovf;
      logic         mt;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic         cmp_wr = 1'b0;
   logic [W-1:0] cmp_wdata = '0;
   logic [1:0]   out_mode = 2'b00;
   logic         pwm_out;
   logic [W-1:0] count;
   logic         ovf_pulse;
   logic         match_pulse;

   int   checks = 0;
   int   errors = 0;
   exp_t q[$];

   logic [W-1:0] m_cnt = '0;
   logic         m_up  = 1'b1;
   logic [W-1:0] m_buf = '0;
   logic [W-1:0] m_act = '0;
   logic         m_oc  = 1'b0;

   always #2.5 clk = ~clk;

   pcpwm_timer #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_wr(cmp_wr),
      .cmp_wdata(cmp_wdata), .out_mode(out_mode), .pwm_out(pwm_out),
      .count(count), .ovf_pulse(ovf_pulse), .match_pulse(match_pulse)
   );

   task automatic chk(input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t",
                  req, what, act, exp, $time);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input bit t, input bit w, input logic [W-1:0] d,
                       input logic [1:0] m, input string tag);
      exp_t e;
      bit   mt, ov, ld;
      @(negedge clk);
      tick = t; cmp_wr = w; cmp_wdata = d; out_mode = m;
      mt = t && (m_cnt == m_act);
      if (mt) begin
         case (m)
            2'b01: m_oc = ~m_oc;
            2'b10: m_oc = ~m_up;
            2'b11: m_oc = m_up;
            default: ;
         endcase
      end
      ov = 1'b0;
      ld = t && m_up && (m_cnt == TOP - 1);
      if (t) begin
         if (m_up) begin
            m_cnt = m_cnt + 1'b1;
            if (m_cnt == TOP) m_up = 1'b0;
         end else begin
            m_cnt = m_cnt - 1'b1;
            if (m_cnt == 0) begin m_up = 1'b1; ov = 1'b1; end
         end
      end
      if (ld) m_act = m_buf;
      if (w)  m_buf = d;
      e.cnt = m_cnt; e.pin = (m == 2'b00) ? 1'b0 : m_oc;
      e.ovf = ov; e.mt = mt; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic run(input int n, input int every, input logic [1:0] m,
                      input string tag);
      for (int i = 0; i < n; i++)
         step((i % every) == 0, 1'b0, '0, m, tag);
   endtask

   // monitor: pops expected items and compares them with the outputs
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk((e.tag == "R2") ? "R2" : "R1", "count", count, e.cnt);
            chk("R3", "ovf_pulse", ovf_pulse, e.ovf);
            chk("R4", "match_pulse", match_pulse, e.mt);
            chk(e.tag, "pwm_out", pwm_out, e.pin);
         end
      end
   end

   // watchdog
   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R11 reset state
      chk("R11", "count", count, 0);
      chk("R11", "pwm_out", pwm_out, 0);
      chk("R11", "ovf_pulse", ovf_pulse, 0);
      chk("R11", "match_pulse", match_pulse, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 non-inverting, mid threshold
      step(1'b1, 1'b1, 8'd100, 2'b10, "R5");
      run(1100, 1, 2'b10, "R5");
      // R9 writes scattered across both slopes
      for (int k = 0; k < 16; k++) begin
         step(1'b1, 1'b1, 8'(k * 37 + 5), 2'b10, "R9");
         run(61 + k * 7, 1, 2'b10, "R9");
      end
      // R6 inverting
      step(1'b1, 1'b1, 8'd60, 2'b11, "R6");
      run(1100, 1, 2'b11, "R6");
      // R2 sparse ticks
      step(1'b1, 1'b1, 8'd200, 2'b10, "R2");
      run(3200, 3, 2'b10, "R2");
      // R10 threshold 0, then MAX
      step(1'b1, 1'b1, 8'd0, 2'b10, "R10");
      run(1100, 1, 2'b10, "R10");
      step(1'b1, 1'b1, TOP, 2'b10, "R10");
      run(1100, 1, 2'b10, "R10");
      // R7 toggle
      step(1'b1, 1'b1, 8'd33, 2'b01, "R7");
      run(1100, 1, 2'b01, "R7");
      // R8 off
      step(1'b1, 1'b1, 8'd128, 2'b00, "R8");
      run(700, 1, 2'b00, "R8");
      // R5 again after off: internal state unaffected by matches in off mode
      run(600, 1, 2'b10, "R8");

      repeat (3) @(posedge clk);
      #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule